// File: doc/BRIEF.md
# DDS Control Word Loader and Phase Accumulator

This block is the host-facing programming front end of a direct digital synthesizer, together with its phase accumulator. A host writes a 40-bit control word into a staging (input) register, either one byte per strobe over an 8-bit data port or one bit per strobe over the top data line. The staging register holds an 8-bit control byte and a 32-bit frequency tuning word. A separate update strobe copies the whole staging register into the active register in one step. The active register drives the accumulator, so a half-written word never reaches the output.

The load strobe and the update strobe are asynchronous to the system clock. Each passes through a two-flop synchronizer, and only its rising edge acts. The data lines are not synchronized, so the host must hold them steady from a load strobe's rising edge until at least three system clocks later.

Every system clock, the accumulator adds the active tuning word, wrapping modulo 2^32. The phase output is the top 14 accumulator bits plus a 5-bit phase offset taken from the control byte, wrapping modulo 2^14. Reset returns the output to 0 Hz and 0 degrees and puts the port back in parallel mode. It does not touch the staging register.

Top module: `dds_word_loader`

## Requirements
- R1: While reset is high and on the first clock after it, phase_o, ftw_o, ctrl_o, mult_o and serial_o are all zero.
- R2: In parallel mode, five load strobes fill the staging register. The first byte is the control byte, and the next four are tuning-word bytes from bits 31:24 down to 7:0. data_i[7] is the MSB of each byte.
- R3: The active word (ftw_o, ctrl_o) changes only on an update strobe rising edge, which copies all 40 staging bits at once. Loads without an update leave the active word unchanged.
- R4: The byte position counter wraps to the control byte after five loads. Both an update strobe and a reset return it to the control byte.
- R5: Reset leaves the staging register unchanged. An update issued after reset applies the word that was staged before reset.
- R6: On every system clock the accumulator adds ftw_o, wrapping modulo 2^32. After N clocks the phase has advanced by N*(ftw/2^18) mod 2^14 when ftw is a multiple of 2^18.
- R7: phase_o equals accumulator bits 31:18 plus (ctrl_o[7:3] << 9), modulo 2^14.
- R8: An update that applies a control byte with bit 1 set puts the port in serial mode (serial_o = 1). Serial mode then persists across later updates until reset.
- R9: In serial mode each load strobe shifts data_i[7] into the staging register, least significant bit first. The first of 40 bits lands in tuning-word bit 0 and the last in control bit 7. data_i[6:0] are ignored.
- R10: mult_o follows bit 0 of the active control byte, which enables the reference clock multiplier.
- R11: A strobe held high for many clocks acts once, on its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk_i | input | 1 | Asynchronous load strobe, acts on its rising edge |
| fqud_i | input | 1 | Asynchronous update strobe, acts on its rising edge |
| data_i | input | 8 | Parallel byte, or serial bit on bit 7 |
| phase_o | output | 14 | Phase value including offset |
| ftw_o | output | 32 | Active frequency tuning word |
| ctrl_o | output | 8 | Active control byte |
| serial_o | output | 1 | High while the port is in serial mode |
| mult_o | output | 1 | Reference multiplier enable from the active control byte |

## Verification
A wrong byte counter or shift direction does not show at the ports while loading, because the staging register is hidden. It appears three clocks after the next update strobe, as a rotated or mismatched ftw_o and ctrl_o. A faulty accumulator or offset adder shows on phase_o on the very next clock, as a wrong step between consecutive samples or a wrong constant offset when the tuning word is zero. A reset that corrupts the staging register is caught by the first update after reset.

// File: rtl/dds_word_loader.sv
module dds_word_loader #(
  parameter int FTW_W   = 32,
  parameter int CTRL_W  = 8,
  parameter int BYTE_W  = 8,
  parameter int PH_W    = 14,
  parameter int OFS_W   = 5,
  parameter int SER_BIT = 1,
  parameter int MUL_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wclk_i,
  input  logic              fqud_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [PH_W-1:0]   phase_o,
  output logic [FTW_W-1:0]  ftw_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              serial_o,
  output logic              mult_o
);

  localparam int WORD_W = FTW_W + CTRL_W;
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES);

  logic [2:0]        wsync, usync;
  logic              w_rise, u_rise;
  logic [WORD_W-1:0] stage;
  logic [CNT_W-1:0]  bcnt;
  logic [FTW_W-1:0]  acc;
  logic              serial_q;

  always_ff @(posedge clk) begin
    wsync <= {wsync[1:0], wclk_i};
    usync <= {usync[1:0], fqud_i};
  end

  assign w_rise = wsync[1] & ~wsync[2];
  assign u_rise = usync[1] & ~usync[2];

  always_ff @(posedge clk) begin
    if (!rst && w_rise) begin
      if (serial_q) begin
        stage <= {data_i[BYTE_W-1], stage[WORD_W-1:1]};
      end else begin
        for (int i = 0; i < NBYTES; i++)
          if (bcnt == CNT_W'(i))
            stage[WORD_W-1-i*BYTE_W -: BYTE_W] <= data_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || u_rise)
      bcnt <= '0;
    else if (w_rise && !serial_q)
      bcnt <= (bcnt == CNT_W'(NBYTES-1)) ? '0 : bcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_o    <= '0;
      ctrl_o   <= '0;
      serial_q <= 1'b0;
    end else if (u_rise) begin
      ftw_o  <= stage[FTW_W-1:0];
      ctrl_o <= stage[WORD_W-1 -: CTRL_W];
      if (stage[FTW_W+SER_BIT]) serial_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + ftw_o;
  end

  assign phase_o  = acc[FTW_W-1 -: PH_W] + {ctrl_o[CTRL_W-1 -: OFS_W], {(PH_W-OFS_W){1'b0}}};
  assign serial_o = serial_q;
  assign mult_o   = ctrl_o[MUL_BIT];

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (acc == '0 && ftw_o == '0 && ctrl_o == '0 && !serial_q));

  a_r3_active_holds: assert property (@(posedge clk) disable iff (rst)
    !u_rise |=> $stable({ctrl_o, ftw_o}));

  a_r4_count_range: assert property (@(posedge clk)
    bcnt < CNT_W'(NBYTES));

  a_r4_update_rewinds: assert property (@(posedge clk)
    (rst || u_rise) |=> bcnt == '0);

  a_r5_stage_kept: assert property (@(posedge clk)
    rst |=> $stable(stage));

  a_r6_acc_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> acc == $past(acc) + $past(ftw_o));

  a_r8_serial_sticky: assert property (@(posedge clk) disable iff (rst)
    serial_q |=> serial_q);

endmodule

// File: tb/tb_dds_word_loader.sv
module tb_dds_word_loader;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam logic [39:0] VEC [NV] = '{
    40'h09_12345678,
    40'hF8_FFFFFFFF,
    40'h00_00000001,
    40'hA5_80000000,
    40'h28_0000C000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wclk = 1'b0;
  logic fqud = 1'b0;
  logic [7:0] data = 8'h00;
  logic [13:0] phase;
  logic [31:0] ftw;
  logic [7:0] ctrl;
  logic ser, mul;
  int n_run = 0;
  int n_fail = 0;
  logic [13:0] p1, p2;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_word_loader dut (
    .clk(clk), .rst(rst), .wclk_i(wclk), .fqud_i(fqud), .data_i(data),
    .phase_o(phase), .ftw_o(ftw), .ctrl_o(ctrl), .serial_o(ser), .mult_o(mul)
  );

  task automatic check(input string req, input logic [39:0] got, input logic [39:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic strobe_w(input logic [7:0] d, input int hold);
    @(negedge clk);
    data = d;
    wclk = 1'b1;
    repeat (hold) @(negedge clk);
    wclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe_u();
    @(negedge clk);
    fqud = 1'b1;
    repeat (4) @(negedge clk);
    fqud = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_par(input logic [39:0] w);
    for (int i = 0; i < 5; i++) strobe_w(w[39-8*i -: 8], 4);
  endtask

  task automatic load_ser(input logic [39:0] w, input logic [6:0] junk);
    for (int i = 0; i < 40; i++) strobe_w({w[i], junk ^ 7'(i)}, 4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_word(input string req, input logic [39:0] w);
    check(req, {8'h0, ftw}, {8'h0, w[31:0]});
    check(req, {32'h0, ctrl}, {32'h0, w[39:32]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset phase", {26'h0, phase}, 40'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {ftw, ctrl}, 40'h0);
    check("R1 flags", {38'h0, ser, mul}, 40'h0);

    // R2 R3 R10: table of parallel loads
    for (int v = 0; v < NV; v++) begin
      load_par(VEC[v]);
      strobe_u();
      check_word("R2 parallel load", VEC[v]);
      check("R10 mult", {39'h0, mul}, {39'h0, VEC[v][32]});
    end

    // R3: staged word not applied without update
    load_par(40'h10_DEADBEEF);
    check_word("R3 no update", VEC[NV-1]);
    strobe_u();
    check_word("R3 after update", 40'h10_DEADBEEF);

    // R4: counter wrap after five loads
    load_par(40'h00_11223344);
    strobe_w(8'h40, 4);
    strobe_w(8'h99, 4);
    strobe_u();
    check_word("R4 wrap", 40'h40_99223344);

    // R4: update rewinds counter
    strobe_w(8'hC0, 4);
    strobe_w(8'h55, 4);
    strobe_u();
    load_par(40'h08_01020304);
    strobe_u();
    check_word("R4 update rewind", 40'h08_01020304);

    // R4: reset rewinds counter
    strobe_w(8'hE0, 4);
    strobe_w(8'h77, 4);
    do_reset();
    load_par(40'h18_A0B0C0D0);
    strobe_u();
    check_word("R4 reset rewind", 40'h18_A0B0C0D0);

    // R11: long strobe acts once
    strobe_w(8'h20, 30);
    strobe_w(8'h01, 4);
    strobe_w(8'h02, 4);
    strobe_w(8'h03, 4);
    strobe_w(8'h04, 4);
    strobe_u();
    check_word("R11 long strobe", 40'h20_01020304);

    // R5: reset keeps staged word, R1/R10 reset clears active and mult
    load_par(40'h09_CAFE0000);
    strobe_u();
    load_par(40'h30_00ABCDEF);
    do_reset();
    check("R1 active cleared", {ftw, ctrl}, 40'h0);
    check("R10 mult cleared", {39'h0, mul}, 40'h0);
    strobe_u();
    check_word("R5 staged kept", 40'h30_00ABCDEF);

    // R7: offset only, accumulator zero
    do_reset();
    load_par(40'h28_00000000);
    strobe_u();
    check("R7 offset 5", {26'h0, phase}, 40'd2560);

    // R6: step of 3 per clock
    do_reset();
    load_par(40'h00_000C0000);
    strobe_u();
    p1 = phase;
    repeat (10) @(negedge clk);
    p2 = phase;
    check("R6 step", {26'h0, 14'(p2 - p1)}, 40'd30);

    // R6 R7: wrapping step with full offset
    load_par(40'hF8_0FA00000);
    strobe_u();
    p1 = phase;
    repeat (20) @(negedge clk);
    p2 = phase;
    check("R6 wrap step", {26'h0, 14'(p2 - p1)}, 40'd3616);

    // R8: enter serial mode
    do_reset();
    load_par(40'h02_00000000);
    strobe_u();
    check("R8 serial on", {39'h0, ser}, 40'h1);

    // R9: serial load, junk on low lines
    load_ser(40'h81_13579BDF, 7'h5A);
    strobe_u();
    check_word("R9 serial load", 40'h81_13579BDF);
    check("R8 sticky", {39'h0, ser}, 40'h1);
    check("R10 mult serial", {39'h0, mul}, 40'h1);

    // R8: reset returns to parallel
    do_reset();
    check("R8 reset parallel", {39'h0, ser}, 40'h0);
    load_par(40'h00_87654321);
    strobe_u();
    check_word("R2 parallel after serial", 40'h00_87654321);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule